// File: doc/BRIEF.md
# Parallel Memory Programming Sequencer

This block drives the pins of a target device's parallel programming port. The port has an 8-bit data bus, split here into an output byte, an output-enable for that byte and an input byte. It also has a two-bit mode selector, a byte selector, an active-low read enable, an active-low write strobe, a latch clock and a ready return line. A host asks for one primitive bus phase at a time. The phases are: latch a command, latch a low or high address byte, latch a data byte, strobe a low or high byte write, or read a low or high byte back. The block produces each phase with fixed setup and pulse widths counted in system clock cycles.

A small controller sits on the same pin engine. It programs a group of four bytes into consecutive low addresses and reads the group back. It then reports whether every byte matched, and returns the bytes it read. A write whose ready line never comes back within a bounded wait ends with an error flag, whether the write was issued by the host or by the controller.

Top module: `par_prog_seq`

## Requirements
- R1: After reset, mode_sel is 2'b11, byte_sel is 0, oe_n and wr_n are 1, latch_clk is 0, bus_drv is 0 and busy is 0.
- R2: The latch phases are selected by op_kind: 0 = command, 1 = low address, 2 = high address, 3 = data. Each sets mode_sel (command 2'b10, address 2'b00, data 2'b01) and drives op_arg on bus_out with bus_drv high. Address phases set byte_sel to 0 for the low byte and 1 for the high byte. After SETUP cycles, latch_clk goes high for PULSE cycles, and mode_sel, byte_sel and bus_out stay steady throughout that pulse.
- R3: When a data latch phase ends, mode_sel returns to 2'b00 in the same cycle that latch_clk falls.
- R4: op_kind 4 writes the low byte and op_kind 5 writes the high byte. byte_sel takes the value 0 or 1 respectively, then wr_n is held low for PULSE cycles. The operation completes only once rdy has been seen high after the strobe, with op_err low.
- R5: If rdy stays low for RDY_TMO cycles after a write strobe, the operation ends with op_done and op_err both high.
- R6: op_kind 6 reads the low byte and op_kind 7 reads the high byte. byte_sel is set, bus_drv drops before oe_n goes low, and bus_in is sampled after SETUP cycles. rd_data holds that byte when op_done pulses, and oe_n returns high.
- R7: No two of latch_clk high, wr_n low and oe_n low occur in the same cycle.
- R8: A vfy_start programs byte i of vfy_data (bits 8i+7:8i) at low address vfy_base+i. Each byte is programmed with command 8'h11, a low address latch, a data latch and a low-byte write. The controller then reads each byte with command 8'h03 and a low-byte read. vfy_pass is 1 when all four bytes match, and vfy_rdback holds the bytes read, in the same bit positions.
- R9: If any read-back byte differs, vfy_pass is 0 and vfy_rdback still holds every byte as read.
- R10: A ready timeout during the group ends the group at once: vfy_done rises with vfy_err 1 and vfy_pass 0.
- R11: op_valid and vfy_start are ignored while busy is high. When both arrive in the same idle cycle, the group starts and the host phase is dropped.
- R12: op_done never pulses for the controller's internal phases, and op_done and vfy_done are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | Host phase request, taken when idle |
| op_kind | input | 3 | Phase selector (encoding in R2, R4, R6) |
| op_arg | input | 8 | Byte for latch phases |
| vfy_start | input | 1 | Start of a four-byte program-and-check group |
| vfy_base | input | 8 | First low address of the group |
| vfy_data | input | 32 | Four bytes to program, byte 0 in bits 7:0 |
| busy | output | 1 | A phase or group is in progress |
| op_done | output | 1 | One-cycle end of a host phase |
| op_err | output | 1 | Ready timeout, valid with op_done |
| rd_data | output | 8 | Byte read by a host read phase |
| vfy_done | output | 1 | One-cycle end of a group |
| vfy_pass | output | 1 | All four bytes matched |
| vfy_err | output | 1 | Group ended by ready timeout |
| vfy_rdback | output | 32 | Bytes read back during the group |
| bus_out | output | 8 | Byte driven toward the target |
| bus_drv | output | 1 | Drive enable for bus_out |
| bus_in | input | 8 | Byte returned by the target |
| mode_sel | output | 2 | Phase mode lines, high bit first |
| byte_sel | output | 1 | Low (0) or high (1) byte select |
| oe_n | output | 1 | Active-low read enable |
| wr_n | output | 1 | Active-low write strobe |
| latch_clk | output | 1 | Latch pulse for each phase |
| rdy | input | 1 | Target ready, high when idle |

## Verification
A host phase request and a group start can land in the same idle cycle, and both want the one pin engine. The bench raises op_valid with a distinctive command byte and vfy_start on the same clock. It then checks that the command latched by the target model is the controller's read command, not the host byte, and that op_done never pulsed while the group ran. A second host request made mid-group is judged the same way.

// File: rtl/par_prog_seq_pkg.sv
package par_prog_seq_pkg;
  typedef enum logic [2:0] {
    K_CMD = 3'd0,
    K_ALO = 3'd1,
    K_AHI = 3'd2,
    K_DAT = 3'd3,
    K_WLO = 3'd4,
    K_WHI = 3'd5,
    K_RLO = 3'd6,
    K_RHI = 3'd7
  } kind_e;

  localparam logic [1:0] MODE_IDLE = 2'b11;
  localparam logic [1:0] MODE_CMD  = 2'b10;
  localparam logic [1:0] MODE_ADDR = 2'b00;
  localparam logic [1:0] MODE_DATA = 2'b01;

  localparam logic [7:0] CMD_PROG_BYTE = 8'h11;
  localparam logic [7:0] CMD_READ_BYTE = 8'h03;
endpackage

// File: rtl/par_prog_pin_engine.sv
module par_prog_pin_engine
  import par_prog_seq_pkg::*;
#(
  parameter int SETUP   = 4,
  parameter int PULSE   = 4,
  parameter int RDY_TMO = 4096
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        req,
  input  kind_e       kind,
  input  logic [7:0]  arg,
  output logic        busy,
  output logic        done,
  output logic        tmo,
  output logic [7:0]  rdata,
  output logic [7:0]  bus_out,
  output logic        bus_drv,
  input  logic [7:0]  bus_in,
  output logic [1:0]  mode_sel,
  output logic        byte_sel,
  output logic        oe_n,
  output logic        wr_n,
  output logic        latch_clk,
  input  logic        rdy
);
  localparam int MAXC = (SETUP > PULSE) ? SETUP : PULSE;
  localparam int CW   = $clog2(MAXC + 1);
  localparam int TW   = $clog2(RDY_TMO + 1);

  typedef enum logic [2:0] {S_IDLE, S_SETUP, S_PULSE, S_WAIT, S_SETTLE} st_e;

  st_e           st;
  kind_e         k;
  logic [CW-1:0] cnt;
  logic [TW-1:0] tcnt;
  logic          rdy_q;

  assign busy = (st != S_IDLE);

  always_ff @(posedge clk) begin
    rdy_q <= rdy;
    done  <= 1'b0;
    tmo   <= 1'b0;
    if (rst) begin
      st        <= S_IDLE;
      k         <= K_CMD;
      cnt       <= '0;
      tcnt      <= '0;
      mode_sel  <= MODE_IDLE;
      byte_sel  <= 1'b0;
      oe_n      <= 1'b1;
      wr_n      <= 1'b1;
      latch_clk <= 1'b0;
      bus_drv   <= 1'b0;
      bus_out   <= 8'h00;
      rdata     <= 8'h00;
    end else begin
      case (st)
        S_IDLE: if (req) begin
          k   <= kind;
          cnt <= CW'(SETUP - 1);
          st  <= S_SETUP;
          case (kind)
            K_CMD: begin mode_sel <= MODE_CMD;  byte_sel <= 1'b0; bus_drv <= 1'b1; bus_out <= arg; end
            K_ALO: begin mode_sel <= MODE_ADDR; byte_sel <= 1'b0; bus_drv <= 1'b1; bus_out <= arg; end
            K_AHI: begin mode_sel <= MODE_ADDR; byte_sel <= 1'b1; bus_drv <= 1'b1; bus_out <= arg; end
            K_DAT: begin mode_sel <= MODE_DATA; bus_drv <= 1'b1; bus_out <= arg; end
            K_WLO: byte_sel <= 1'b0;
            K_WHI: byte_sel <= 1'b1;
            K_RLO: begin byte_sel <= 1'b0; bus_drv <= 1'b0; end
            K_RHI: begin byte_sel <= 1'b1; bus_drv <= 1'b0; end
            default: ;
          endcase
        end
        S_SETUP: begin
          if (cnt != '0) cnt <= cnt - 1'b1;
          else if (!k[2]) begin
            latch_clk <= 1'b1;
            cnt       <= CW'(PULSE - 1);
            st        <= S_PULSE;
          end else if (!k[1]) begin
            wr_n <= 1'b0;
            cnt  <= CW'(PULSE - 1);
            st   <= S_PULSE;
          end else begin
            oe_n <= 1'b0;
            cnt  <= CW'(SETUP - 1);
            st   <= S_SETTLE;
          end
        end
        S_PULSE: begin
          if (cnt != '0) cnt <= cnt - 1'b1;
          else begin
            latch_clk <= 1'b0;
            wr_n      <= 1'b1;
            if (k == K_DAT) mode_sel[0] <= 1'b0;
            if (k[2]) begin
              tcnt <= '0;
              st   <= S_WAIT;
            end else begin
              done <= 1'b1;
              st   <= S_IDLE;
            end
          end
        end
        S_WAIT: begin
          if (rdy_q) begin
            done <= 1'b1;
            st   <= S_IDLE;
          end else if (tcnt == TW'(RDY_TMO - 1)) begin
            done <= 1'b1;
            tmo  <= 1'b1;
            st   <= S_IDLE;
          end else begin
            tcnt <= tcnt + 1'b1;
          end
        end
        S_SETTLE: begin
          if (cnt != '0) cnt <= cnt - 1'b1;
          else begin
            rdata <= bus_in;
            oe_n  <= 1'b1;
            done  <= 1'b1;
            st    <= S_IDLE;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/par_prog_verify_ctrl.sv
module par_prog_verify_ctrl
  import par_prog_seq_pkg::*;
#(
  parameter int GROUP = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [7:0]        base,
  input  logic [8*GROUP-1:0] wdata,
  input  logic              eng_done,
  input  logic              eng_tmo,
  input  logic [7:0]        eng_rdata,
  output logic              req,
  output kind_e             kind,
  output logic [7:0]        arg,
  output logic              busy,
  output logic              done,
  output logic              pass,
  output logic              err,
  output logic [8*GROUP-1:0] rdback
);
  localparam int IW = (GROUP > 1) ? $clog2(GROUP) : 1;

  typedef enum logic [1:0] {C_IDLE, C_ISSUE, C_WAIT} cst_e;

  cst_e             st;
  logic             rd_ph;
  logic [IW-1:0]    idx;
  logic [1:0]       sub;
  logic             miss;
  logic [7:0]       base_q;
  logic [8*GROUP-1:0] data_q;
  logic [7:0]       cur_byte;
  logic             last_sub;
  logic             this_miss;

  assign busy      = (st != C_IDLE);
  assign req       = (st == C_ISSUE);
  assign cur_byte  = data_q[8*idx +: 8];
  assign last_sub  = rd_ph ? (sub == 2'd2) : (sub == 2'd3);
  assign this_miss = (eng_rdata != cur_byte);

  always_comb begin
    kind = K_CMD;
    arg  = 8'h00;
    if (!rd_ph) begin
      case (sub)
        2'd0: begin kind = K_CMD; arg = CMD_PROG_BYTE; end
        2'd1: begin kind = K_ALO; arg = base_q + 8'(idx); end
        2'd2: begin kind = K_DAT; arg = cur_byte; end
        default: kind = K_WLO;
      endcase
    end else begin
      case (sub)
        2'd0: begin kind = K_CMD; arg = CMD_READ_BYTE; end
        2'd1: begin kind = K_ALO; arg = base_q + 8'(idx); end
        default: kind = K_RLO;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    done <= 1'b0;
    if (rst) begin
      st     <= C_IDLE;
      rd_ph  <= 1'b0;
      idx    <= '0;
      sub    <= '0;
      miss   <= 1'b0;
      base_q <= 8'h00;
      data_q <= '0;
      pass   <= 1'b0;
      err    <= 1'b0;
      rdback <= '0;
    end else begin
      case (st)
        C_IDLE: if (start) begin
          base_q <= base;
          data_q <= wdata;
          rd_ph  <= 1'b0;
          idx    <= '0;
          sub    <= '0;
          miss   <= 1'b0;
          st     <= C_ISSUE;
        end
        C_ISSUE: st <= C_WAIT;
        C_WAIT: if (eng_done) begin
          if (eng_tmo) begin
            done <= 1'b1;
            err  <= 1'b1;
            pass <= 1'b0;
            st   <= C_IDLE;
          end else begin
            st <= C_ISSUE;
            if (rd_ph && sub == 2'd2) begin
              rdback[8*idx +: 8] <= eng_rdata;
              miss <= miss | this_miss;
            end
            if (!last_sub) begin
              sub <= sub + 1'b1;
            end else begin
              sub <= '0;
              if (idx != IW'(GROUP - 1)) begin
                idx <= idx + 1'b1;
              end else if (!rd_ph) begin
                rd_ph <= 1'b1;
                idx   <= '0;
              end else begin
                done <= 1'b1;
                err  <= 1'b0;
                pass <= !(miss | this_miss);
                st   <= C_IDLE;
              end
            end
          end
        end
        default: st <= C_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/par_prog_seq.sv
module par_prog_seq
  import par_prog_seq_pkg::*;
#(
  parameter int SETUP   = 4,
  parameter int PULSE   = 4,
  parameter int RDY_TMO = 4096
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        op_valid,
  input  logic [2:0]  op_kind,
  input  logic [7:0]  op_arg,
  input  logic        vfy_start,
  input  logic [7:0]  vfy_base,
  input  logic [31:0] vfy_data,
  output logic        busy,
  output logic        op_done,
  output logic        op_err,
  output logic [7:0]  rd_data,
  output logic        vfy_done,
  output logic        vfy_pass,
  output logic        vfy_err,
  output logic [31:0] vfy_rdback,
  output logic [7:0]  bus_out,
  output logic        bus_drv,
  input  logic [7:0]  bus_in,
  output logic [1:0]  mode_sel,
  output logic        byte_sel,
  output logic        oe_n,
  output logic        wr_n,
  output logic        latch_clk,
  input  logic        rdy
);
  logic       eng_busy, eng_done, eng_tmo, eng_req;
  logic [7:0] eng_rdata, eng_arg, c_arg;
  kind_e      eng_kind, c_kind;
  logic       c_req, c_busy;
  logic       host_go, vfy_go;

  // group start wins a same-cycle collision; nothing is taken while busy
  assign vfy_go  = vfy_start & ~eng_busy & ~c_busy;
  assign host_go = op_valid & ~eng_busy & ~c_busy & ~vfy_start;

  assign eng_req  = host_go | c_req;
  assign eng_kind = c_busy ? c_kind : kind_e'(op_kind);
  assign eng_arg  = c_busy ? c_arg  : op_arg;

  assign busy    = eng_busy | c_busy;
  assign op_done = eng_done & ~c_busy;
  assign op_err  = eng_tmo & ~c_busy;
  assign rd_data = eng_rdata;

  par_prog_pin_engine #(
    .SETUP(SETUP), .PULSE(PULSE), .RDY_TMO(RDY_TMO)
  ) u_eng (
    .clk(clk), .rst(rst), .req(eng_req), .kind(eng_kind), .arg(eng_arg),
    .busy(eng_busy), .done(eng_done), .tmo(eng_tmo), .rdata(eng_rdata),
    .bus_out(bus_out), .bus_drv(bus_drv), .bus_in(bus_in),
    .mode_sel(mode_sel), .byte_sel(byte_sel), .oe_n(oe_n), .wr_n(wr_n),
    .latch_clk(latch_clk), .rdy(rdy)
  );

  par_prog_verify_ctrl #(.GROUP(4)) u_ctrl (
    .clk(clk), .rst(rst), .start(vfy_go), .base(vfy_base), .wdata(vfy_data),
    .eng_done(eng_done), .eng_tmo(eng_tmo), .eng_rdata(eng_rdata),
    .req(c_req), .kind(c_kind), .arg(c_arg), .busy(c_busy),
    .done(vfy_done), .pass(vfy_pass), .err(vfy_err), .rdback(vfy_rdback)
  );
endmodule

// File: rtl/par_prog_seq_chk.sv
module par_prog_seq_chk (
  input logic       clk,
  input logic       rst,
  input logic       op_done,
  input logic       vfy_done,
  input logic [7:0] bus_out,
  input logic       bus_drv,
  input logic [1:0] mode_sel,
  input logic       byte_sel,
  input logic       oe_n,
  input logic       wr_n,
  input logic       latch_clk
);
  assert_idle_after_reset_R1: assert property (@(posedge clk)
    $past(rst) && !rst |-> mode_sel == 2'b11 && oe_n && wr_n && !latch_clk && !byte_sel && !bus_drv);

  assert_latch_steady_R2: assert property (@(posedge clk) disable iff (rst)
    latch_clk && $past(latch_clk) |-> $stable(mode_sel) && $stable(bus_out) && $stable(byte_sel) && bus_drv);

  assert_data_mode_drop_R3: assert property (@(posedge clk) disable iff (rst)
    $fell(latch_clk) && $past(mode_sel) == 2'b01 |-> mode_sel == 2'b00);

  assert_read_released_R6: assert property (@(posedge clk) disable iff (rst)
    !oe_n |-> !bus_drv);

  assert_strobe_excl_R7: assert property (@(posedge clk) disable iff (rst)
    $countones({latch_clk, ~wr_n, ~oe_n}) <= 1);

  assert_done_excl_R12: assert property (@(posedge clk) disable iff (rst)
    !(op_done && vfy_done));
endmodule

bind par_prog_seq par_prog_seq_chk u_chk (
  .clk(clk), .rst(rst), .op_done(op_done), .vfy_done(vfy_done),
  .bus_out(bus_out), .bus_drv(bus_drv), .mode_sel(mode_sel), .byte_sel(byte_sel),
  .oe_n(oe_n), .wr_n(wr_n), .latch_clk(latch_clk)
);

// File: tb/par_prog_seq_bench.sv
module par_prog_seq_bench;
  localparam int CLK_PERIOD = 10;
  localparam int SETUP      = 4;
  localparam int PULSE      = 4;
  localparam int RDY_TMO    = 50;
  localparam int BUSY_LEN   = 6;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        op_valid = 1'b0;
  logic [2:0]  op_kind = 3'd0;
  logic [7:0]  op_arg = 8'h00;
  logic        vfy_start = 1'b0;
  logic [7:0]  vfy_base = 8'h00;
  logic [31:0] vfy_data = 32'h0;
  logic        busy, op_done, op_err, vfy_done, vfy_pass, vfy_err;
  logic [7:0]  rd_data, bus_out, bus_in;
  logic [31:0] vfy_rdback;
  logic        bus_drv, byte_sel, oe_n, wr_n, latch_clk;
  logic [1:0]  mode_sel;
  logic        rdy = 1'b1;

  int total = 0;
  int bad   = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  par_prog_seq #(.SETUP(SETUP), .PULSE(PULSE), .RDY_TMO(RDY_TMO)) u_par_prog_seq (
    .clk(clk), .rst(rst), .op_valid(op_valid), .op_kind(op_kind), .op_arg(op_arg),
    .vfy_start(vfy_start), .vfy_base(vfy_base), .vfy_data(vfy_data),
    .busy(busy), .op_done(op_done), .op_err(op_err), .rd_data(rd_data),
    .vfy_done(vfy_done), .vfy_pass(vfy_pass), .vfy_err(vfy_err), .vfy_rdback(vfy_rdback),
    .bus_out(bus_out), .bus_drv(bus_drv), .bus_in(bus_in), .mode_sel(mode_sel),
    .byte_sel(byte_sel), .oe_n(oe_n), .wr_n(wr_n), .latch_clk(latch_clk), .rdy(rdy)
  );

  // ---- behavioural target ----
  logic [7:0] mem_lo [0:255];
  logic [7:0] mem_hi [0:255];
  logic [7:0] t_cmd = 8'h00, t_alo = 8'h00, t_ahi = 8'h00, t_dat = 8'h00;
  logic       hold_low = 1'b0;
  logic       corrupt  = 1'b0;
  int         bcnt = 0;

  initial for (int i = 0; i < 256; i++) begin mem_lo[i] = 8'h00; mem_hi[i] = 8'h00; end

  always @(posedge latch_clk) begin
    case (mode_sel)
      2'b10: t_cmd <= bus_out;
      2'b00: if (byte_sel) t_ahi <= bus_out; else t_alo <= bus_out;
      2'b01: t_dat <= bus_out;
      default: ;
    endcase
  end

  always @(negedge wr_n) begin
    if (byte_sel) mem_hi[t_alo] <= t_dat; else mem_lo[t_alo] <= t_dat;
  end

  always @(posedge clk) begin
    if (!wr_n) begin rdy <= 1'b0; bcnt <= BUSY_LEN; end
    else if (bcnt != 0) bcnt <= bcnt - 1;
    else if (!hold_low) rdy <= 1'b1;
  end

  always_comb begin
    if (oe_n) bus_in = 8'h00;
    else bus_in = (byte_sel ? mem_hi[t_alo] : mem_lo[t_alo]) ^ (corrupt ? 8'h80 : 8'h00);
  end

  // ---- pin monitors (sampled away from the active edge) ----
  int  xw = 0, ww = 0, mon_bad = 0, stray = 0;
  logic in_vfy = 1'b0;
  always @(negedge clk) begin
    if (latch_clk) xw++;
    else if (xw != 0) begin if (xw != PULSE) mon_bad++; xw = 0; end
    if (!wr_n) ww++;
    else if (ww != 0) begin if (ww != PULSE) mon_bad++; ww = 0; end
    if ((latch_clk && !wr_n) || (latch_clk && !oe_n) || (!wr_n && !oe_n)) mon_bad++;
    if (!oe_n && bus_drv) mon_bad++;
    if (in_vfy && op_done) stray++;
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic do_op(input logic [2:0] kd, input logic [7:0] a,
                       output logic [7:0] rd, output logic er, output int cyc);
    @(negedge clk);
    while (busy) @(negedge clk);
    op_valid = 1'b1; op_kind = kd; op_arg = a;
    @(negedge clk);
    op_valid = 1'b0;
    cyc = 1;
    while (!op_done && cyc < 5000) begin @(negedge clk); cyc++; end
    rd = rd_data; er = op_err;
  endtask

  task automatic do_vfy(input logic [7:0] b, input logic [31:0] d, input logic collide,
                        output int cyc);
    @(negedge clk);
    while (busy) @(negedge clk);
    vfy_start = 1'b1; vfy_base = b; vfy_data = d;
    if (collide) begin op_valid = 1'b1; op_kind = 3'd0; op_arg = 8'h5A; end
    in_vfy = 1'b1;
    @(negedge clk);
    vfy_start = 1'b0; op_valid = 1'b0;
    cyc = 1;
    while (!vfy_done && cyc < 20000) begin
      @(negedge clk); cyc++;
      if (collide && cyc == 30) begin op_valid = 1'b1; op_kind = 3'd0; op_arg = 8'h77; end
      if (collide && cyc == 31) op_valid = 1'b0;
    end
    in_vfy = 1'b0;
  endtask

  // {kind, arg, expected read byte}
  localparam int NV = 17;
  localparam logic [18:0] VEC [0:NV-1] = '{
    {3'd0, 8'h11, 8'h00}, {3'd1, 8'h05, 8'h00}, {3'd3, 8'hA5, 8'h00}, {3'd4, 8'h00, 8'h00},
    {3'd0, 8'h10, 8'h00}, {3'd1, 8'h06, 8'h00}, {3'd3, 8'h3C, 8'h00}, {3'd5, 8'h00, 8'h00},
    {3'd0, 8'h03, 8'h00}, {3'd1, 8'h05, 8'h00}, {3'd6, 8'h00, 8'hA5},
    {3'd0, 8'h02, 8'h00}, {3'd1, 8'h06, 8'h00}, {3'd7, 8'h00, 8'h3C},
    {3'd1, 8'h06, 8'h00}, {3'd6, 8'h00, 8'h00}, {3'd2, 8'h7E, 8'h00}
  };

  initial begin
    repeat (150000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [7:0] rd;
    logic       er;
    int         cyc;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk("R1 idle pins", {23'd0, mode_sel, byte_sel, oe_n, wr_n, latch_clk, bus_drv, busy},
        {23'd0, 2'b11, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0});

    for (int i = 0; i < NV; i++) begin
      logic [2:0] kd;
      logic [7:0] a, ex;
      {kd, a, ex} = VEC[i];
      do_op(kd, a, rd, er, cyc);
      case (kd)
        3'd0: chk("R2 command latched", {24'd0, t_cmd}, {24'd0, a});
        3'd1: chk("R2 low address latched", {24'd0, t_alo}, {24'd0, a});
        3'd2: chk("R2 high address latched", {24'd0, t_ahi}, {24'd0, a});
        3'd3: begin
          chk("R2 data latched", {24'd0, t_dat}, {24'd0, a});
          chk("R3 mode back to 00", {30'd0, mode_sel}, 32'd0);
        end
        3'd4, 3'd5: begin
          chk("R4 write ok, rdy seen", {30'd0, er, rdy}, {30'd0, 1'b0, 1'b1});
          chk("R4 completes after busy", (cyc > SETUP + PULSE + BUSY_LEN) ? 32'd1 : 32'd0, 32'd1);
        end
        default: begin
          chk("R6 read byte", {24'd0, rd}, {24'd0, ex});
          chk("R6 oe_n back high", {31'd0, oe_n}, 32'd1);
        end
      endcase
    end
    chk("R2 high byte stored by high write", {24'd0, mem_hi[6]}, 32'h3C);

    // R5 ready timeout
    hold_low = 1'b1;
    do_op(3'd4, 8'h00, rd, er, cyc);
    chk("R5 timeout flag", {31'd0, er}, 32'd1);
    chk("R5 wait length", (cyc >= RDY_TMO) ? 32'd1 : 32'd0, 32'd1);
    hold_low = 1'b0;
    repeat (BUSY_LEN + 4) @(negedge clk);

    // R8 group pass
    do_vfy(8'h20, 32'h44332211, 1'b0, cyc);
    chk("R8 pass", {30'd0, vfy_pass, vfy_err}, {30'd0, 1'b1, 1'b0});
    chk("R8 readback", vfy_rdback, 32'h44332211);
    chk("R8 byte order in target", {24'd0, mem_lo[8'h21]}, 32'h22);

    // R9 mismatch
    corrupt = 1'b1;
    do_vfy(8'h40, 32'hDDCCBBAA, 1'b0, cyc);
    corrupt = 1'b0;
    chk("R9 fail", {31'd0, vfy_pass}, 32'd0);
    chk("R9 readback as read", vfy_rdback, 32'h5D4C3B2A);

    // R10 timeout inside group
    hold_low = 1'b1;
    do_vfy(8'h60, 32'h01020304, 1'b0, cyc);
    chk("R10 group error", {30'd0, vfy_err, vfy_pass}, {30'd0, 1'b1, 1'b0});
    hold_low = 1'b0;
    repeat (BUSY_LEN + 4) @(negedge clk);

    // R11 collision and request while busy
    stray = 0;
    do_vfy(8'h80, 32'hCAFE0001, 1'b1, cyc);
    chk("R11 group ran", {30'd0, vfy_pass, vfy_err}, {30'd0, 1'b1, 1'b0});
    chk("R11 host command dropped", {24'd0, t_cmd}, 32'h03);
    chk("R12 no op_done during group", stray, 0);

    chk("R7 strobe exclusivity and pulse widths", mon_bad, 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule